// File: doc/BRIEF.md
# Superscalar In-Order Issue Window

This block is the issue stage of a multi-issue pipeline. It holds up to `W` decoded instructions in a window of slots. Each instruction carries a destination register and two source registers. Every cycle all occupied slots are checked in parallel. An instruction is held back when it reads or overwrites a register written by an older instruction still in the window, or when one of its sources is marked busy by work already in flight. Issue is strictly in program order: the oldest blocked instruction stops every younger one, even if the younger ones are independent. The block reports which slots issue this cycle, how many issue, and the register fields of those slots.

The window is fed from an external buffer of decoded instructions. The buffer presents its oldest `W` entries and a count of how many of them are valid. The block returns how many entries it takes at the next clock edge.

A parameter selects one of two refill modes:
- In gliding mode, issued instructions are shifted out. The freed slots are refilled from the buffer at the same edge, so the window always holds the oldest unissued instructions.
- In fixed mode, slots keep their positions. Nothing new enters until every instruction of the current window group has issued.

Top module: `inorder_issue_window`

## Requirements
- R1: While reset is asserted the window is emptied. On the first cycle after reset no slot issues, and the issue count is zero.
- R2: Instructions issue in the order they were taken from the buffer. Slot 0 holds the oldest instruction. In gliding mode the issuing slots always form a contiguous run starting at slot 0.
- R3: An instruction whose source equals the destination of an older instruction still in the window does not issue. No younger instruction issues in that cycle.
- R4: An instruction whose destination equals the destination of an older instruction still in the window does not issue. No younger instruction issues in that cycle.
- R5: An instruction does not issue while the busy bit of either of its source registers is set. Bit n of `busy_regs` marks register n.
- R6: An unoccupied slot never issues. `issue_cnt` equals the number of set bits in `issue_vld`.
- R7: `buf_take` never exceeds `buf_cnt`, and it is zero while reset is asserted.
- R8: In gliding mode, at each edge the unissued instructions move down to the lowest slots. The window takes min(free slots after issue, `buf_cnt`) new entries, placed behind them in buffer order.
- R9: In fixed mode, `buf_take` is zero while any occupied slot stays unissued. Once all occupied slots issue, or the window is empty, the block takes min(`W`, `buf_cnt`) entries into slots 0 upward.
- R10: A stream of mutually independent instructions with no busy sources issues `W` per cycle. Every instruction taken from the buffer eventually issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| busy_regs | input | NREG | One bit per register; a set bit means a write to that register is in flight |
| buf_cnt | input | CW | Number of valid entries presented by the buffer (0 to W) |
| buf_src1 | input | W*RW | First source register of buffer entries; entry k at bits k*RW upward, entry 0 oldest |
| buf_src2 | input | W*RW | Second source register of buffer entries, same layout |
| buf_dst | input | W*RW | Destination register of buffer entries, same layout |
| buf_take | output | CW | Number of buffer entries consumed at the next rising edge |
| issue_vld | output | W | Per-slot issue flag for the current cycle |
| issue_cnt | output | CW | Number of slots issuing this cycle |
| issue_src1 | output | W*RW | First source register held in each slot |
| issue_src2 | output | W*RW | Second source register held in each slot |
| issue_dst | output | W*RW | Destination register held in each slot |

## Verification
The bench builds two copies side by side, both with `W`=4 and `NREG`=16: one in gliding mode and one in fixed mode. Both copies receive the same program and the same busy pattern. A single in-window dependency therefore yields distinct per-cycle issue counts and slot patterns in the two modes (1-4-3 against 1-3-4). This exposes the hold-until-drained rule next to immediate refill. A four-wide window leaves room for a blocked instruction with independent younger instructions behind it, and for a buffer that runs dry with fewer than `W` entries left.

// File: rtl/iwin_pkg.sv
package iwin_pkg;

   typedef enum logic {
      WIN_GLIDE = 1'b0,
      WIN_FIXED = 1'b1
   } win_mode_e;

   function automatic int min_int(int a, int b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/iwin_hazard.sv
module iwin_hazard #(
   parameter int W    = 4,
   parameter int NREG = 32,
   parameter int RW   = 5
) (
   input  logic [W-1:0]    vld,
   input  logic [RW-1:0]   s1  [W],
   input  logic [RW-1:0]   s2  [W],
   input  logic [RW-1:0]   dst [W],
   input  logic [NREG-1:0] busy,
   output logic [W-1:0]    blocked
);

   for (genvar i = 0; i < W; i++) begin : g_slot
      logic raw;
      logic waw;
      logic pend;

      always_comb begin
         raw = 1'b0;
         waw = 1'b0;
         for (int j = 0; j < i; j++) begin
            if (vld[j]) begin
               if (dst[j] == s1[i] || dst[j] == s2[i]) raw = 1'b1;
               if (dst[j] == dst[i])                   waw = 1'b1;
            end
         end
      end

      assign pend       = busy[s1[i]] | busy[s2[i]];
      assign blocked[i] = vld[i] & (raw | waw | pend);
   end

endmodule

// File: rtl/iwin_select.sv
module iwin_select #(
   parameter int W  = 4,
   parameter int CW = 3
) (
   input  logic [W-1:0]  vld,
   input  logic [W-1:0]  blocked,
   output logic [W-1:0]  issue,
   output logic [CW-1:0] cnt
);

   logic go;

   always_comb begin
      go  = 1'b1;
      cnt = '0;
      for (int i = 0; i < W; i++) begin
         issue[i] = go & vld[i] & ~blocked[i];
         if (blocked[i]) go = 1'b0;
         cnt = cnt + CW'(issue[i]);
      end
   end

endmodule

// File: rtl/iwin_refill.sv
module iwin_refill
   import iwin_pkg::*;
#(
   parameter int        W    = 4,
   parameter int        RW   = 5,
   parameter int        CW   = 3,
   parameter win_mode_e MODE = WIN_GLIDE
) (
   input  logic [W-1:0]  vld,
   input  logic [W-1:0]  issue,
   input  logic [RW-1:0] s1   [W],
   input  logic [RW-1:0] s2   [W],
   input  logic [RW-1:0] dst  [W],
   input  logic [CW-1:0] buf_cnt,
   input  logic [RW-1:0] b_s1  [W],
   input  logic [RW-1:0] b_s2  [W],
   input  logic [RW-1:0] b_dst [W],
   output logic [W-1:0]  n_vld,
   output logic [RW-1:0] n_s1  [W],
   output logic [RW-1:0] n_s2  [W],
   output logic [RW-1:0] n_dst [W],
   output logic [CW-1:0] take
);

   if (MODE == WIN_GLIDE) begin : g_glide
      int occ;
      int gone;
      int keep;
      int take_i;

      always_comb begin
         occ  = 0;
         gone = 0;
         for (int i = 0; i < W; i++) begin
            occ  = occ  + int'(vld[i]);
            gone = gone + int'(issue[i]);
         end
         keep   = occ - gone;
         take_i = min_int(W - keep, min_int(W, int'(buf_cnt)));
         for (int k = 0; k < W; k++) begin
            n_vld[k] = 1'b0;
            n_s1[k]  = '0;
            n_s2[k]  = '0;
            n_dst[k] = '0;
            if (k < keep) begin
               for (int m = 0; m < W; m++) begin
                  if (m == k + gone) begin
                     n_vld[k] = 1'b1;
                     n_s1[k]  = s1[m];
                     n_s2[k]  = s2[m];
                     n_dst[k] = dst[m];
                  end
               end
            end else if (k - keep < take_i) begin
               for (int m = 0; m < W; m++) begin
                  if (m == k - keep) begin
                     n_vld[k] = 1'b1;
                     n_s1[k]  = b_s1[m];
                     n_s2[k]  = b_s2[m];
                     n_dst[k] = b_dst[m];
                  end
               end
            end
         end
         take = CW'(take_i);
      end
   end else begin : g_fixed
      logic drained;
      int   take_i;

      assign drained = ~|(vld & ~issue);

      always_comb begin
         take_i = drained ? min_int(W, int'(buf_cnt)) : 0;
         for (int k = 0; k < W; k++) begin
            if (drained) begin
               n_vld[k] = (k < take_i);
               n_s1[k]  = b_s1[k];
               n_s2[k]  = b_s2[k];
               n_dst[k] = b_dst[k];
            end else begin
               n_vld[k] = vld[k] & ~issue[k];
               n_s1[k]  = s1[k];
               n_s2[k]  = s2[k];
               n_dst[k] = dst[k];
            end
         end
         take = CW'(take_i);
      end
   end

endmodule

// File: rtl/inorder_issue_window.sv
module inorder_issue_window
   import iwin_pkg::*;
#(
   parameter int        W    = 4,
   parameter int        NREG = 32,
   parameter win_mode_e MODE = WIN_GLIDE,
   localparam int       RW   = $clog2(NREG),
   localparam int       CW   = $clog2(W + 1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NREG-1:0] busy_regs,
   input  logic [CW-1:0]   buf_cnt,
   input  logic [W*RW-1:0] buf_src1,
   input  logic [W*RW-1:0] buf_src2,
   input  logic [W*RW-1:0] buf_dst,
   output logic [CW-1:0]   buf_take,
   output logic [W-1:0]    issue_vld,
   output logic [CW-1:0]   issue_cnt,
   output logic [W*RW-1:0] issue_src1,
   output logic [W*RW-1:0] issue_src2,
   output logic [W*RW-1:0] issue_dst
);

   if (W < 2 || W > 8) begin : g_bad_width
      $error("inorder_issue_window: W must lie in 2..8");
   end
   if (NREG < 2 || (1 << RW) != NREG) begin : g_bad_regs
      $error("inorder_issue_window: NREG must be a power of two, at least 2");
   end

   logic [W-1:0]  win_vld;
   logic [RW-1:0] win_s1  [W];
   logic [RW-1:0] win_s2  [W];
   logic [RW-1:0] win_dst [W];

   logic [RW-1:0] b_s1  [W];
   logic [RW-1:0] b_s2  [W];
   logic [RW-1:0] b_dst [W];

   logic [W-1:0]  n_vld;
   logic [RW-1:0] n_s1  [W];
   logic [RW-1:0] n_s2  [W];
   logic [RW-1:0] n_dst [W];

   logic [W-1:0]  blocked;
   logic [W-1:0]  issue;
   logic [CW-1:0] cnt;
   logic [CW-1:0] take;

   for (genvar k = 0; k < W; k++) begin : g_unpack
      assign b_s1[k]                  = buf_src1[k*RW +: RW];
      assign b_s2[k]                  = buf_src2[k*RW +: RW];
      assign b_dst[k]                 = buf_dst[k*RW +: RW];
      assign issue_src1[k*RW +: RW]   = win_s1[k];
      assign issue_src2[k*RW +: RW]   = win_s2[k];
      assign issue_dst[k*RW +: RW]    = win_dst[k];
   end

   iwin_hazard #(.W(W), .NREG(NREG), .RW(RW)) u_hazard (
      .vld     (win_vld),
      .s1      (win_s1),
      .s2      (win_s2),
      .dst     (win_dst),
      .busy    (busy_regs),
      .blocked (blocked)
   );

   iwin_select #(.W(W), .CW(CW)) u_select (
      .vld     (win_vld),
      .blocked (blocked),
      .issue   (issue),
      .cnt     (cnt)
   );

   iwin_refill #(.W(W), .RW(RW), .CW(CW), .MODE(MODE)) u_refill (
      .vld     (win_vld),
      .issue   (issue),
      .s1      (win_s1),
      .s2      (win_s2),
      .dst     (win_dst),
      .buf_cnt (buf_cnt),
      .b_s1    (b_s1),
      .b_s2    (b_s2),
      .b_dst   (b_dst),
      .n_vld   (n_vld),
      .n_s1    (n_s1),
      .n_s2    (n_s2),
      .n_dst   (n_dst),
      .take    (take)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         win_vld <= '0;
         for (int k = 0; k < W; k++) begin
            win_s1[k]  <= '0;
            win_s2[k]  <= '0;
            win_dst[k] <= '0;
         end
      end else begin
         win_vld <= n_vld;
         win_s1  <= n_s1;
         win_s2  <= n_s2;
         win_dst <= n_dst;
      end
   end

   assign issue_vld = issue;
   assign issue_cnt = cnt;
   assign buf_take  = rst ? '0 : take;

endmodule

// File: rtl/iwin_checker.sv
module iwin_checker
   import iwin_pkg::*;
#(
   parameter int        W    = 4,
   parameter int        NREG = 32,
   parameter int        RW   = 5,
   parameter int        CW   = 3,
   parameter win_mode_e MODE = WIN_GLIDE
) (
   input logic            clk,
   input logic            rst,
   input logic [NREG-1:0] busy_regs,
   input logic [CW-1:0]   buf_cnt,
   input logic [CW-1:0]   buf_take,
   input logic [W-1:0]    issue_vld,
   input logic [CW-1:0]   issue_cnt,
   input logic [W-1:0]    win_vld,
   input logic [RW-1:0]   head_s1,
   input logic [RW-1:0]   head_s2
);

   // R1: a reset edge leaves nothing to issue
   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> (issue_vld == '0));

   // R6: only occupied slots issue
   assert_no_empty_issue_R6: assert property (@(posedge clk) disable iff (rst)
      ((issue_vld & ~win_vld) == '0));

   // R6: count agrees with the flags
   assert_cnt_popcount_R6: assert property (@(posedge clk) disable iff (rst)
      (int'(issue_cnt) == $countones(issue_vld)));

   // R7: never take more than the buffer offers
   assert_take_bound_R7: assert property (@(posedge clk) disable iff (rst)
      (buf_take <= buf_cnt));

   // R5: head slot with a busy source stalls everything
   assert_busy_head_R5: assert property (@(posedge clk) disable iff (rst)
      (win_vld[0] && (busy_regs[head_s1] || busy_regs[head_s2])) |-> (issue_cnt == '0));

   if (MODE == WIN_GLIDE) begin : g_glide_chk
      // R2: issuing slots form a run from slot 0
      assert_prefix_issue_R2: assert property (@(posedge clk) disable iff (rst)
         (((issue_vld + W'(1)) & issue_vld) == '0));

      // R8: occupancy follows issue and take
      assert_occupancy_R8: assert property (@(posedge clk) disable iff (rst)
         1'b1 |=> ($countones(win_vld) ==
                   $countones($past(win_vld)) - int'($past(issue_cnt)) + int'($past(buf_take))));
   end else begin : g_fixed_chk
      // R9: no refill while a slot remains unissued
      assert_hold_until_drained_R9: assert property (@(posedge clk) disable iff (rst)
         (|(win_vld & ~issue_vld)) |-> (buf_take == '0));
   end

endmodule

bind inorder_issue_window iwin_checker #(
   .W(W), .NREG(NREG), .RW(RW), .CW(CW), .MODE(MODE)
) u_iwin_chk (
   .clk       (clk),
   .rst       (rst),
   .busy_regs (busy_regs),
   .buf_cnt   (buf_cnt),
   .buf_take  (buf_take),
   .issue_vld (issue_vld),
   .issue_cnt (issue_cnt),
   .win_vld   (win_vld),
   .head_s1   (win_s1[0]),
   .head_s2   (win_s2[0])
);

// File: tb/inorder_issue_window_tb_top.sv
module inorder_issue_window_tb_top;
   import iwin_pkg::*;

   localparam int  W          = 4;
   localparam int  NREG       = 16;
   localparam int  RW         = 4;
   localparam int  CW         = 3;
   localparam time CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic [NREG-1:0] busy = '0;
   logic [3*RW-1:0] prog [32];
   int end_p = 0;
   int ptr_g = 0;
   int ptr_f = 0;

   logic [CW-1:0]   cnt_g, cnt_f, take_g, take_f, icnt_g, icnt_f;
   logic [W*RW-1:0] bs1_g, bs2_g, bd_g, bs1_f, bs2_f, bd_f;
   logic [W*RW-1:0] is1_g, is2_g, id_g, is1_f, is2_f, id_f;
   logic [W-1:0]    iv_g, iv_f;

   // buffer model: presents oldest entries from the program
   always_comb begin
      for (int k = 0; k < W; k++) begin
         bd_g[k*RW +: RW]  = (ptr_g + k < end_p) ? prog[ptr_g + k][11:8] : '0;
         bs1_g[k*RW +: RW] = (ptr_g + k < end_p) ? prog[ptr_g + k][7:4]  : '0;
         bs2_g[k*RW +: RW] = (ptr_g + k < end_p) ? prog[ptr_g + k][3:0]  : '0;
         bd_f[k*RW +: RW]  = (ptr_f + k < end_p) ? prog[ptr_f + k][11:8] : '0;
         bs1_f[k*RW +: RW] = (ptr_f + k < end_p) ? prog[ptr_f + k][7:4]  : '0;
         bs2_f[k*RW +: RW] = (ptr_f + k < end_p) ? prog[ptr_f + k][3:0]  : '0;
      end
      cnt_g = CW'((end_p - ptr_g >= W) ? W : end_p - ptr_g);
      cnt_f = CW'((end_p - ptr_f >= W) ? W : end_p - ptr_f);
   end

   inorder_issue_window #(.W(W), .NREG(NREG), .MODE(WIN_GLIDE)) dut_i (
      .clk(clk), .rst(rst), .busy_regs(busy), .buf_cnt(cnt_g),
      .buf_src1(bs1_g), .buf_src2(bs2_g), .buf_dst(bd_g), .buf_take(take_g),
      .issue_vld(iv_g), .issue_cnt(icnt_g),
      .issue_src1(is1_g), .issue_src2(is2_g), .issue_dst(id_g)
   );

   inorder_issue_window #(.W(W), .NREG(NREG), .MODE(WIN_FIXED)) dut_a (
      .clk(clk), .rst(rst), .busy_regs(busy), .buf_cnt(cnt_f),
      .buf_src1(bs1_f), .buf_src2(bs2_f), .buf_dst(bd_f), .buf_take(take_f),
      .issue_vld(iv_f), .issue_cnt(icnt_f),
      .issue_src1(is1_f), .issue_src2(is2_f), .issue_dst(id_f)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [3*RW-1:0] q_g [$];
   logic [3*RW-1:0] q_f [$];

   int         rc_g [8];
   int         rc_f [8];
   logic [W-1:0] rv_g [8];
   logic [W-1:0] rv_f [8];
   int         rt_g [8];
   int         rt_f [8];

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // driver side of the scoreboard: consumed entries become expected issues
   task automatic push_taken(int sel, int from, int n);
      for (int k = 0; k < n; k++) begin
         if (sel == 0) q_g.push_back(prog[from + k]);
         else          q_f.push_back(prog[from + k]);
      end
   endtask

   // monitor side: every issuing slot, oldest first, pops one expected entry
   task automatic mon(int sel);
      logic [W-1:0]    iv;
      logic [W*RW-1:0] a1, a2, ad;
      logic [3*RW-1:0] got, exp;
      iv = (sel == 0) ? iv_g  : iv_f;
      a1 = (sel == 0) ? is1_g : is1_f;
      a2 = (sel == 0) ? is2_g : is2_f;
      ad = (sel == 0) ? id_g  : id_f;
      for (int s = 0; s < W; s++) begin
         if (iv[s]) begin
            got = {ad[s*RW +: RW], a1[s*RW +: RW], a2[s*RW +: RW]};
            if ((sel == 0 && q_g.size() == 0) || (sel == 1 && q_f.size() == 0)) begin
               chk(1'b0, "R6", "issue with no outstanding entry", int'(got), -1);
            end else begin
               exp = (sel == 0) ? q_g.pop_front() : q_f.pop_front();
               chk(got == exp, "R2", "issued entry order", int'(got), int'(exp));
            end
         end
      end
   endtask

   task automatic run_case(int base, int n, int cycles, int busy_reg, int busy_until);
      int lt_g;
      int lt_f;
      rst = 1'b1;
      busy = '0;
      q_g.delete();
      q_f.delete();
      ptr_g = base;
      ptr_f = base;
      end_p = base + n;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      if (busy_reg >= 0) busy[busy_reg] = 1'b1;
      #1;
      chk(iv_g == '0 && icnt_g == '0, "R1", "glide issue after reset", int'(iv_g), 0);
      chk(iv_f == '0 && icnt_f == '0, "R1", "fixed issue after reset", int'(iv_f), 0);
      chk(int'(take_g) == ((n < W) ? n : W), "R8", "glide first take", int'(take_g), (n < W) ? n : W);
      chk(int'(take_f) == ((n < W) ? n : W), "R9", "fixed first take", int'(take_f), (n < W) ? n : W);
      lt_g = int'(take_g);
      lt_f = int'(take_f);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         push_taken(0, ptr_g, lt_g);
         push_taken(1, ptr_f, lt_f);
         ptr_g = ptr_g + lt_g;
         ptr_f = ptr_f + lt_f;
         if (c == busy_until) busy = '0;
         #1;
         rc_g[c] = int'(icnt_g);
         rc_f[c] = int'(icnt_f);
         rv_g[c] = iv_g;
         rv_f[c] = iv_f;
         rt_g[c] = int'(take_g);
         rt_f[c] = int'(take_f);
         mon(0);
         mon(1);
         lt_g = int'(take_g);
         lt_f = int'(take_f);
      end
      chk(q_g.size() == 0, "R10", "glide entries left unissued", q_g.size(), 0);
      chk(q_f.size() == 0, "R10", "fixed entries left unissued", q_f.size(), 0);
   endtask

   task automatic exp_cycle(string req, int c, int eg, logic [W-1:0] vg, int ef, logic [W-1:0] vf);
      chk(rc_g[c] == eg, req, $sformatf("glide count cycle %0d", c), rc_g[c], eg);
      chk(rv_g[c] == vg, req, $sformatf("glide flags cycle %0d", c), int'(rv_g[c]), int'(vg));
      chk(rc_f[c] == ef, req, $sformatf("fixed count cycle %0d", c), rc_f[c], ef);
      chk(rv_f[c] == vf, req, $sformatf("fixed flags cycle %0d", c), int'(rv_f[c]), int'(vf));
   endtask

   initial begin
      // independent stream: dst 1..8, sources 9 and 10
      for (int i = 0; i < 8; i++) prog[i] = {RW'(i + 1), 4'd9, 4'd10};
      // RAW: entry 9 reads register 1 written by entry 8
      prog[8]  = {4'd1, 4'd9, 4'd9};
      prog[9]  = {4'd2, 4'd1, 4'd9};
      for (int i = 10; i < 16; i++) prog[i] = {RW'(i - 7), 4'd9, 4'd10};
      // busy source on src2 of the head, then WAW on register 5
      prog[16] = {4'd5, 4'd13, 4'd9};
      prog[17] = {4'd5, 4'd10, 4'd10};
      prog[18] = {4'd6, 4'd11, 4'd11};
      prog[19] = {4'd7, 4'd12, 4'd12};
      // short buffer of two
      prog[20] = {4'd9, 4'd1, 4'd2};
      prog[21] = {4'd10, 4'd3, 4'd4};
      for (int i = 22; i < 32; i++) prog[i] = '0;

      // R10: full-width throughput
      run_case(0, 8, 4, -1, 0);
      exp_cycle("R10", 0, 4, 4'b1111, 4, 4'b1111);
      exp_cycle("R10", 1, 4, 4'b1111, 4, 4'b1111);
      exp_cycle("R6",  2, 0, 4'b0000, 0, 4'b0000);

      // R3: in-window RAW; modes diverge (R8 vs R9)
      run_case(8, 8, 4, -1, 0);
      exp_cycle("R3", 0, 1, 4'b0001, 1, 4'b0001);
      exp_cycle("R8", 1, 4, 4'b1111, 3, 4'b1110);
      exp_cycle("R9", 2, 3, 4'b0111, 4, 4'b1111);
      exp_cycle("R6", 3, 0, 4'b0000, 0, 4'b0000);
      chk(rt_g[0] == 1, "R8", "glide refill take cycle 0", rt_g[0], 1);
      chk(rt_f[0] == 0, "R9", "fixed hold take cycle 0", rt_f[0], 0);
      chk(rt_g[1] == 3, "R8", "glide take limited by buffer", rt_g[1], 3);
      chk(rt_f[1] == 4, "R9", "fixed reload after drain", rt_f[1], 4);

      // R5 then R4: busy source stalls, then WAW stops the second entry
      run_case(16, 4, 5, 9, 2);
      exp_cycle("R5", 0, 0, 4'b0000, 0, 4'b0000);
      exp_cycle("R5", 1, 0, 4'b0000, 0, 4'b0000);
      exp_cycle("R4", 2, 1, 4'b0001, 1, 4'b0001);
      exp_cycle("R2", 3, 3, 4'b0111, 3, 4'b1110);
      exp_cycle("R6", 4, 0, 4'b0000, 0, 4'b0000);

      // R7: buffer holds fewer than W entries
      run_case(20, 2, 3, -1, 0);
      exp_cycle("R7", 0, 2, 4'b0011, 2, 4'b0011);
      exp_cycle("R6", 1, 0, 4'b0000, 0, 4'b0000);
      chk(rt_g[0] == 0 && rt_f[0] == 0, "R7", "take with empty buffer", rt_g[0] + rt_f[0], 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule